// File: doc/BRIEF.md
# Low-Power Halt/Hold Mode Manager

This block sits beside the control core of a small 8-bit processor. It follows whether the processor is running, stopped by a halt instruction, or has given the bus to another master. From that it decides when the core enters a low-power state and when it leaves it. It takes four inputs:

- a one-cycle strobe when a halt instruction executes;
- an asynchronous bus-hold request from another master;
- a one-cycle pulse from the interrupt logic when an interrupt is accepted;
- a busy level that is high while a bus transfer is still in progress.

It drives four outputs: a power-down flag that the clock-gating logic uses, the hold acknowledge, a bus-float enable for the address, data and strobe drivers, and a code that records which event started the current power-down.

The two ways into power-down have different rules for leaving it. A halt-started power-down wakes only on reset or an accepted interrupt. Taking and then dropping the bus does not wake it: after the hold ends, the block returns to the halted low-power state. A hold-started power-down ignores interrupts and wakes only on reset or when the hold request is withdrawn. Reset always returns the block to the running state with the acknowledge cleared.

Top module: `pdm_manager`

## Requirements
- R1: On a rising edge with `rst` high, the block returns to its idle values: `pd_flag`=0, `hold_ack`=0, `pd_cause`=2'b00 (none) and `bus_float`=0.
- R2: If `halt_strobe` is high while the block runs and the hold is not acknowledged, then after that rising edge `pd_flag`=1 and `pd_cause`=2'b01 (halt).
- R3: In a halt-started power-down with the hold not acknowledged, an `irq_taken` pulse clears `pd_flag` and sets `pd_cause` to 2'b00 at that rising edge.
- R4: `hold_req` passes through `SYNC_STAGES` flops clocked on the falling edge. With the default of 2 and the bus idle, a request changed just after rising edge 0 shows on `hold_ack` after rising edge 2, and a withdrawal shows with the same latency.
- R5: While `bus_busy` is high, a new hold request is not acknowledged. The acknowledge rises on the first rising edge at which `bus_busy` is low. Once `hold_ack` is high, `bus_busy` has no effect on it.
- R6: While the block is running, `hold_ack` high at a rising edge enters power-down with `pd_flag`=1 and `pd_cause`=2'b10 (hold). This is one edge after the acknowledge rises.
- R7: In a hold-started power-down, `irq_taken` and `halt_strobe` pulses have no effect: `pd_flag` and `pd_cause` are unchanged.
- R8: In a hold-started power-down, `hold_ack` low at a rising edge clears `pd_flag` and sets `pd_cause` to 2'b00.
- R9: In a halt-started power-down, acknowledging and then withdrawing a hold leaves `pd_flag`=1 and `pd_cause`=2'b01. An `irq_taken` pulse while the hold is still acknowledged is ignored.
- R10: After such a hold has ended, an `irq_taken` pulse still wakes the block (`pd_flag`=0).
- R11: Reset leaves either power-down immediately and clears `hold_ack`, even while `hold_req` stays high.
- R12: `bus_float` rises on the falling edge that follows the rise of `hold_ack`, and it falls on the falling edge that follows the fall of `hold_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processor clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_strobe | input | 1 | One-cycle pulse when a halt instruction executes |
| irq_taken | input | 1 | One-cycle pulse when an interrupt is accepted |
| hold_req | input | 1 | Asynchronous bus-hold request from another master |
| bus_busy | input | 1 | High while a bus transfer is still in progress |
| hold_ack | output | 1 | Hold acknowledge to the requesting master |
| bus_float | output | 1 | Floats the bus drivers, half a clock behind the acknowledge |
| pd_flag | output | 1 | Low-power state active; gates the internal clocks |
| pd_cause | output | 2 | Entry path: 00 none, 01 halt, 10 hold |

## Verification
The bench crosses each entry path with every release event, including the ones that must be ignored. A design that mixed up the two rule sets would wake a halted core when the bus comes back, or wake a held core on an interrupt. A hold that arrives during a halt is the sharpest case. Returning to run instead of to the halted low-power state would let the core resume past its halt. Exact-cycle checks on the acknowledge, the power-down entry and the half-cycle bus float catch a missing or extra synchroniser stage. A test with a transfer in progress catches an acknowledge that grabs the bus in the middle of that transfer.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int CAUSE_W = 2;

  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_HALT_PD   = 2'd1,
    ST_HOLD_PD   = 2'd2,
    ST_HALT_HELD = 2'd3
  } pd_state_e;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 2'b00;
  localparam logic [CAUSE_W-1:0] CAUSE_HALT = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_HOLD = 2'b10;
endpackage

// File: rtl/pdm_sync.sv
// Falling-edge synchroniser chain for an asynchronous level.
module pdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(negedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(negedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdm_hold_hs.sv
// Hold handshake: acknowledge on rising edge, bus float half a cycle later.
module pdm_hold_hs (
  input  logic clk,
  input  logic rst,
  input  logic hold_sync,
  input  logic bus_busy,
  output logic hold_ack,
  output logic bus_float
);
  always_ff @(posedge clk) begin
    if (rst)             hold_ack <= 1'b0;
    else if (!hold_sync) hold_ack <= 1'b0;
    else if (!bus_busy)  hold_ack <= 1'b1;
  end

  always_ff @(negedge clk) begin
    if (rst) bus_float <= 1'b0;
    else     bus_float <= hold_ack;
  end
endmodule

// File: rtl/pdm_mode_fsm.sv
// Entry and release rules for the two power-down paths.
module pdm_mode_fsm
  import pdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_strobe,
  input  logic               irq_taken,
  input  logic               hold_ack,
  output logic               pd_flag,
  output logic [CAUSE_W-1:0] pd_cause
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (hold_ack)         state_d = ST_HOLD_PD;
        else if (halt_strobe) state_d = ST_HALT_PD;
      end
      ST_HALT_PD: begin
        if (hold_ack)       state_d = ST_HALT_HELD;
        else if (irq_taken) state_d = ST_RUN;
      end
      ST_HALT_HELD: begin
        if (!hold_ack) state_d = irq_taken ? ST_RUN : ST_HALT_PD;
      end
      ST_HOLD_PD: begin
        if (!hold_ack) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      pd_flag  <= 1'b0;
      pd_cause <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      pd_flag <= (state_d != ST_RUN);
      unique case (state_d)
        ST_HALT_PD, ST_HALT_HELD: pd_cause <= CAUSE_HALT;
        ST_HOLD_PD:               pd_cause <= CAUSE_HOLD;
        default:                  pd_cause <= CAUSE_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pdm_manager.sv
module pdm_manager
  import pdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_strobe,
  input  logic               irq_taken,
  input  logic               hold_req,
  input  logic               bus_busy,
  output logic               hold_ack,
  output logic               bus_float,
  output logic               pd_flag,
  output logic [CAUSE_W-1:0] pd_cause
);
  logic hold_sync;

  pdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hold_req),
    .q   (hold_sync)
  );

  pdm_hold_hs u_hs (
    .clk       (clk),
    .rst       (rst),
    .hold_sync (hold_sync),
    .bus_busy  (bus_busy),
    .hold_ack  (hold_ack),
    .bus_float (bus_float)
  );

  pdm_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .halt_strobe (halt_strobe),
    .irq_taken   (irq_taken),
    .hold_ack    (hold_ack),
    .pd_flag     (pd_flag),
    .pd_cause    (pd_cause)
  );
endmodule

// File: rtl/pdm_manager_chk.sv
module pdm_manager_chk
  import pdm_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               halt_strobe,
  input logic               irq_taken,
  input logic               bus_busy,
  input logic               hold_ack,
  input logic               pd_flag,
  input logic [CAUSE_W-1:0] pd_cause
);
  p_halt_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (!pd_flag && !hold_ack && halt_strobe) |=> (pd_flag && pd_cause == CAUSE_HALT));

  p_irq_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == CAUSE_HALT && !hold_ack && irq_taken) |=> !pd_flag);

  p_ack_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> !$past(bus_busy));

  p_hold_enter_r6: assert property (@(posedge clk) disable iff (rst)
    (!pd_flag && hold_ack) |=> (pd_flag && pd_cause == CAUSE_HOLD));

  p_hold_ignores_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == CAUSE_HOLD && hold_ack) |=> (pd_flag && pd_cause == CAUSE_HOLD));

  p_hold_release_r8: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == CAUSE_HOLD && !hold_ack) |=> !pd_flag);

  p_halt_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (pd_cause == CAUSE_HALT && !irq_taken) |=> (pd_flag && pd_cause == CAUSE_HALT));
endmodule

bind pdm_manager pdm_manager_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt_strobe (halt_strobe),
  .irq_taken   (irq_taken),
  .bus_busy    (bus_busy),
  .hold_ack    (hold_ack),
  .pd_flag     (pd_flag),
  .pd_cause    (pd_cause)
);

// File: tb/pdm_manager_tb.sv
`timescale 1ns/100ps
module pdm_manager_tb;
  logic clk = 1'b0;
  logic rst, halt_strobe, irq_taken, hold_req, bus_busy;
  logic hold_ack, bus_float, pd_flag;
  logic [1:0] pd_cause;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdm_manager u_dut (
    .clk(clk), .rst(rst), .halt_strobe(halt_strobe), .irq_taken(irq_taken),
    .hold_req(hold_req), .bus_busy(bus_busy), .hold_ack(hold_ack),
    .bus_float(bus_float), .pd_flag(pd_flag), .pd_cause(pd_cause)
  );

  // Vector: {halt, irq, hold, busy, exp_pd, exp_ack, exp_cause[1:0], req[3:0]}
  localparam int NV = 16;
  localparam logic [0:NV-1][11:0] VEC = '{
    12'b0000_0000_0001, // idle after reset, R1
    12'b1000_1001_0010, // halt enters, R2
    12'b0010_1101_1001, // hold while halted, R9
    12'b0110_1101_1001, // irq ignored while held in halt, R9
    12'b0000_1001_1001, // hold dropped, stays halted, R9
    12'b0100_0000_1010, // irq wakes after hold ended, R10
    12'b0010_1110_0110, // hold enters, R6
    12'b0110_1110_0111, // irq ignored in hold, R7
    12'b1010_1110_0111, // halt ignored in hold, R7
    12'b0000_0000_1000, // hold removed wakes, R8
    12'b1000_1001_0010, // halt again, R2
    12'b0100_0000_0011, // irq wakes halt, R3
    12'b0011_0000_0101, // busy defers ack, R5
    12'b0010_1110_0101, // busy drops, ack and hold entry, R5
    12'b0011_1110_0101, // busy ignored once acked, R5
    12'b0000_0000_1000  // release, R8
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; halt_strobe = 0; irq_taken = 0; hold_req = 0; bus_busy = 0;
    tick(); tick();
    check("R1 reset state", {pd_flag, hold_ack, pd_cause}, 4'b0000);
    @(negedge clk); #1;
    check("R1 float after reset", {3'b0, bus_float}, 4'b0000);
    @(posedge clk); #1;
    rst = 1'b0;
    tick();

    for (int i = 0; i < NV; i++) begin
      halt_strobe = VEC[i][11]; irq_taken = VEC[i][10];
      hold_req = VEC[i][9]; bus_busy = VEC[i][8];
      tick();
      halt_strobe = 0; irq_taken = 0;
      for (int k = 0; k < 4; k++) tick();
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
            {pd_flag, hold_ack, pd_cause}, VEC[i][7:4]);
    end

    // R4, R6, R12 exact timing of the hold path
    tick();
    hold_req = 1;
    tick();
    check("R4 ack not after edge 1", {3'b0, hold_ack}, 4'b0000);
    tick();
    check("R4 ack after edge 2", {3'b0, hold_ack}, 4'b0001);
    check("R6 pd still low at ack edge", {3'b0, pd_flag}, 4'b0000);
    check("R12 float waits for falling edge", {3'b0, bus_float}, 4'b0000);
    @(negedge clk); #1;
    check("R12 float rises half cycle later", {3'b0, bus_float}, 4'b0001);
    @(posedge clk); #1;
    check("R6 hold entry one edge after ack", {pd_flag, 1'b0, pd_cause}, 4'b1010);
    hold_req = 0;
    tick();
    check("R4 ack held after edge 1", {3'b0, hold_ack}, 4'b0001);
    tick();
    check("R4 ack falls after edge 2", {3'b0, hold_ack}, 4'b0000);
    check("R12 float still set", {3'b0, bus_float}, 4'b0001);
    @(negedge clk); #1;
    check("R12 float falls half cycle later", {3'b0, bus_float}, 4'b0000);
    @(posedge clk); #1;
    check("R8 wake one edge after ack falls", {3'b0, pd_flag}, 4'b0000);

    // R2, R3 exact single-edge timing
    halt_strobe = 1; tick(); halt_strobe = 0;
    check("R2 halt entry next edge", {pd_flag, 1'b0, pd_cause}, 4'b1001);
    irq_taken = 1; tick(); irq_taken = 0;
    check("R3 irq wake next edge", {pd_flag, 1'b0, pd_cause}, 4'b0000);

    // R11 reset out of hold power-down with request still high
    hold_req = 1;
    for (int k = 0; k < 4; k++) tick();
    check("R11 in hold before reset", {pd_flag, hold_ack, pd_cause}, 4'b1110);
    rst = 1; tick(); rst = 0;
    check("R11 reset clears hold pd", {pd_flag, hold_ack, pd_cause}, 4'b0000);
    hold_req = 0;
    for (int k = 0; k < 4; k++) tick();

    // R11 reset out of halt power-down
    halt_strobe = 1; tick(); halt_strobe = 0;
    rst = 1; tick(); rst = 0;
    check("R11 reset clears halt pd", {pd_flag, hold_ack, pd_cause}, 4'b0000);
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule